// File: doc/BRIEF.md
# Word-Oriented RAM March Self-Test Engine

This block tests a group of equally sized embedded RAM arrays without outside help. On a start pulse it takes over the address, write-data, write-enable and read-enable pins of every array through a select stage placed in front of each RAM. It drives the same march operation to all arrays in the same cycle. Each read is checked against the value the march predicts, and any difference sets a sticky fail flag for that array. The fault targets are cells stuck at 0 or 1 and coupling between cells. Because the arrays hold words, not single bits, the whole march is repeated once for each of several data backgrounds. This exposes coupling between bits of the same word.

The march applies eleven operations to every address. Written with `b` for the current background and `~b` for its complement, the elements are: ascending (write b); ascending (read b, write ~b); ascending (read ~b, write b); descending (read b, write ~b); descending (read ~b, write b, read b); ascending (read b). For a W-bit word there are log2(W)+1 backgrounds. Once the last operation of the last background has finished, the engine reports completion and gives the RAM pins back to the functional inputs. No pin carries a data stream, so there is no valid/ready handshake and none of the pins has back-pressure. All pins are plain level or pulse control signals. RAM read data is expected one cycle after the read enable.

Top module: `mbist_top`

## Requirements
- R1: When reset (rst_n low) is released, `done` is 0, `busy` is 0 and every bit of `fail` is 0. Each RAM pin carries the matching functional input.
- R2: For each background, the engine issues the elements in this order: wr b | rd b, wr ~b | rd ~b, wr b | rd b, wr ~b | rd ~b, wr b, rd b | rd b. This is 11 operations per address. All operations of an element finish at one address before the engine moves to the next address.
- R3: Elements 0, 1, 2 and 5 visit addresses 0 up to 2^ADDR_W-1. Elements 3 and 4 visit 2^ADDR_W-1 down to 0.
- R4: There are $clog2(DATA_W)+1 backgrounds, applied in index order k. Background 0 is all zeros. For k≥1, bit i of the background equals bit k-1 of the integer i, so k=1 gives ...1010 (bit 0 is 0). Each written or expected value is the background or its bitwise complement.
- R5: Every array gets the same address, data, write enable and read enable in the same cycle. The engine issues exactly one operation per cycle and never raises write and read together.
- R6: RAM read data is sampled one cycle after the read enable. A difference from the expected word sets that array's `fail` bit. The bit stays set until the next accepted start, and the march carries on to the end without change.
- R7: `start` is accepted only while idle or done. An accepted start clears `fail` and `done`, and `busy` goes high on the next cycle. A `start` seen while `busy` is high has no effect on the operation stream.
- R8: After the last operation the engine spends one flush cycle with `busy` high and no RAM access. `done` then goes high and `busy` goes low. This gives 11·2^ADDR_W·NBG+1 busy cycles in all.
- R9: While `busy` is high the functional inputs have no effect on the RAM pins. While `busy` is low, the RAM pins equal the functional inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a self-test run (ignored while busy) |
| busy | output | 1 | Self-test owns the RAM pins |
| done | output | 1 | Run complete; held until next start |
| fail | output | NUM_RAMS | Sticky per-array mismatch flag |
| fn_addr | input | NUM_RAMS*ADDR_W | Functional address, one slice per array |
| fn_wdata | input | NUM_RAMS*DATA_W | Functional write data |
| fn_we | input | NUM_RAMS | Functional write enable |
| fn_re | input | NUM_RAMS | Functional read enable |
| ram_addr | output | NUM_RAMS*ADDR_W | Address to each RAM |
| ram_wdata | output | NUM_RAMS*DATA_W | Write data to each RAM |
| ram_we | output | NUM_RAMS | Write enable to each RAM |
| ram_re | output | NUM_RAMS | Read enable to each RAM |
| ram_rdata | input | NUM_RAMS*DATA_W | Read data from each RAM, valid one cycle after read enable |

## Verification
On every cycle the assertions check the following:
- read and write never coincide;
- an address is held until its element's operations are complete;
- elements only step forward or wrap at a background change;
- a start during a run leaves the engine running;
- fail flags are sticky and are cleared by an accepted start;
- `done` follows only the flush cycle;
- the RAM pins track the functional inputs whenever the engine is idle.

The exact order of operations, the background values, the address direction of each element and the link between an injected stuck-at or coupling fault and the right fail bit can only be shown by the bench. It compares every cycle against its own march model driving faulty RAM models.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int NUM_ELEM     = 6;
  localparam int OPS_PER_ADDR = 11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_DONE
  } mb_state_e;

  // wr = 1 for a write, inv = 1 when the data is the complement of the background
  typedef struct packed {
    logic wr;
    logic inv;
  } mb_op_t;

  // index of the last operation inside element e
  function automatic logic [1:0] elem_last(input logic [2:0] e);
    case (e)
      3'd0, 3'd5: return 2'd0;
      3'd4:       return 2'd2;
      default:    return 2'd1;
    endcase
  endfunction

  function automatic logic elem_down(input logic [2:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  function automatic mb_op_t elem_op(input logic [2:0] e, input logic [1:0] i);
    mb_op_t o;
    o.wr  = 1'b0;
    o.inv = 1'b0;
    case (e)
      3'd0: begin o.wr = 1'b1; o.inv = 1'b0; end
      3'd1, 3'd3: begin
        o.wr  = (i != 2'd0);
        o.inv = (i != 2'd0);
      end
      3'd2: begin
        o.wr  = (i != 2'd0);
        o.inv = (i == 2'd0);
      end
      3'd4: begin
        o.wr  = (i == 2'd1);
        o.inv = (i == 2'd0);
      end
      default: begin o.wr = 1'b0; o.inv = 1'b0; end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/mbist_bg_gen.sv
module mbist_bg_gen #(
  parameter int DATA_W = 8,
  parameter int BG_W   = 2
) (
  input  logic [BG_W-1:0]   bg_idx,
  output logic [DATA_W-1:0] pattern
);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      if (bg_idx == '0) pattern[i] = 1'b0;
      else              pattern[i] = ((i >> (int'(bg_idx) - 1)) & 1) == 1;
    end
  end

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NBG    = 4,
  parameter int BG_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              clr,
  output logic              op_we,
  output logic              op_re,
  output logic              op_inv,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BG_W-1:0]   op_bg
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;
  localparam logic [BG_W-1:0]   BG_LAST  = BG_W'(NBG - 1);
  localparam logic [2:0]        ELEM_END = 3'(NUM_ELEM - 1);

  mb_state_e         state;
  logic [BG_W-1:0]   bg;
  logic [2:0]        elem;
  logic [1:0]        opi;
  logic [ADDR_W-1:0] addr;

  mb_op_t cur;
  logic   last_op, addr_end, last_elem, last_bg, down, issue;

  always_comb begin
    cur       = elem_op(elem, opi);
    down      = elem_down(elem);
    last_op   = (opi == elem_last(elem));
    addr_end  = down ? (addr == '0) : (addr == ADDR_TOP);
    last_elem = (elem == ELEM_END);
    last_bg   = (bg == BG_LAST);
    issue     = (state == ST_RUN);
  end

  assign busy    = (state == ST_RUN) || (state == ST_FLUSH);
  assign done    = (state == ST_DONE);
  assign clr     = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign op_we   = issue && cur.wr;
  assign op_re   = issue && !cur.wr;
  assign op_inv  = cur.inv;
  assign op_addr = addr;
  assign op_bg   = bg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      bg    <= '0;
      elem  <= '0;
      opi   <= '0;
      addr  <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state <= ST_RUN;
            bg    <= '0;
            elem  <= '0;
            opi   <= '0;
            addr  <= '0;
          end
        end
        ST_RUN: begin
          if (!last_op) begin
            opi <= opi + 2'd1;
          end else begin
            opi <= '0;
            if (!addr_end) begin
              addr <= down ? addr - 1'b1 : addr + 1'b1;
            end else if (!last_elem) begin
              elem <= elem + 3'd1;
              addr <= elem_down(elem + 3'd1) ? ADDR_TOP : '0;
            end else if (!last_bg) begin
              bg   <= bg + 1'b1;
              elem <= '0;
              addr <= '0;
            end else begin
              state <= ST_FLUSH;
            end
          end
        end
        ST_FLUSH: state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R5: one operation per cycle at most
  a_r5_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_we, op_re}));

  // R2: address changes only after the last operation of an element at that address
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !last_op) |=> (addr == $past(addr)));

  // R2: elements advance by one or wrap at a new background
  a_r2_elem_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> (state != ST_RUN) || (elem == $past(elem)) ||
      (elem == $past(elem) + 3'd1) || (elem == 3'd0 && $past(elem) == ELEM_END));

  // R7: start during a run leaves the engine running
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && start) |=> busy);

  // R8: done only appears after the flush cycle
  a_r8_done_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state) == ST_FLUSH));

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int NUM_RAMS = 4,
  parameter int DATA_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         chk,
  input  logic [DATA_W-1:0]            exp_data,
  input  logic [NUM_RAMS*DATA_W-1:0]   rdata,
  output logic [NUM_RAMS-1:0]          fail
);

  logic              chk_q;
  logic [DATA_W-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= 1'b0;
      exp_q <= '0;
    end else begin
      chk_q <= chk;
      exp_q <= exp_data;
    end
  end

  for (genvar a = 0; a < NUM_RAMS; a++) begin : g_arr
    logic fail_r;
    logic mism;

    assign mism    = chk_q && (rdata[a*DATA_W +: DATA_W] != exp_q);
    assign fail[a] = fail_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fail_r <= 1'b0;
      else if (clr) fail_r <= 1'b0;
      else          fail_r <= fail_r | mism;
    end

    // R6: a fail flag stays set until a start is accepted
    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_r && !clr) |=> fail_r);

    // R7: an accepted start clears the flag
    a_r7_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !fail_r);
  end

endmodule

// File: rtl/mbist_top.sv
module mbist_top
  import mbist_pkg::*;
#(
  parameter int NUM_RAMS = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output logic                          busy,
  output logic                          done,
  output logic [NUM_RAMS-1:0]           fail,
  input  logic [NUM_RAMS*ADDR_W-1:0]    fn_addr,
  input  logic [NUM_RAMS*DATA_W-1:0]    fn_wdata,
  input  logic [NUM_RAMS-1:0]           fn_we,
  input  logic [NUM_RAMS-1:0]           fn_re,
  output logic [NUM_RAMS*ADDR_W-1:0]    ram_addr,
  output logic [NUM_RAMS*DATA_W-1:0]    ram_wdata,
  output logic [NUM_RAMS-1:0]           ram_we,
  output logic [NUM_RAMS-1:0]           ram_re,
  input  logic [NUM_RAMS*DATA_W-1:0]    ram_rdata
);

  localparam int NBG  = $clog2(DATA_W) + 1;
  localparam int BG_W = (NBG > 1) ? $clog2(NBG) : 1;

  logic              clr, op_we, op_re, op_inv;
  logic [ADDR_W-1:0] op_addr;
  logic [BG_W-1:0]   op_bg;
  logic [DATA_W-1:0] pattern, bist_data;

  mbist_seq #(.ADDR_W(ADDR_W), .NBG(NBG), .BG_W(BG_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .clr     (clr),
    .op_we   (op_we),
    .op_re   (op_re),
    .op_inv  (op_inv),
    .op_addr (op_addr),
    .op_bg   (op_bg)
  );

  mbist_bg_gen #(.DATA_W(DATA_W), .BG_W(BG_W)) u_bg (
    .bg_idx  (op_bg),
    .pattern (pattern)
  );

  assign bist_data = op_inv ? ~pattern : pattern;

  mbist_cmp #(.NUM_RAMS(NUM_RAMS), .DATA_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .chk      (op_re),
    .exp_data (bist_data),
    .rdata    (ram_rdata),
    .fail     (fail)
  );

  for (genvar a = 0; a < NUM_RAMS; a++) begin : g_mux
    assign ram_addr [a*ADDR_W +: ADDR_W] = busy ? op_addr   : fn_addr [a*ADDR_W +: ADDR_W];
    assign ram_wdata[a*DATA_W +: DATA_W] = busy ? bist_data : fn_wdata[a*DATA_W +: DATA_W];
    assign ram_we[a] = busy ? op_we : fn_we[a];
    assign ram_re[a] = busy ? op_re : fn_re[a];

    // R9: functional path owns the RAM whenever the engine is not busy
    a_r9_mux_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ram_we[a] == fn_we[a]) && (ram_re[a] == fn_re[a]) &&
                (ram_addr[a*ADDR_W +: ADDR_W] == fn_addr[a*ADDR_W +: ADDR_W]));
  end

  // R8: done and busy are never high together
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/sim_mbist_top.sv
module sim_mbist_top;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NBG   = $clog2(DW) + 1;
  localparam int FAW   = N * AW;
  localparam int FDW   = N * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done;
  logic [N-1:0]   fail;
  logic [FAW-1:0] fn_addr = '0;
  logic [FDW-1:0] fn_wdata = '0;
  logic [N-1:0]   fn_we = '0, fn_re = '0;
  logic [FAW-1:0] ram_addr;
  logic [FDW-1:0] ram_wdata;
  logic [N-1:0]   ram_we, ram_re;
  logic [FDW-1:0] ram_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_top #(.NUM_RAMS(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .fn_addr(fn_addr), .fn_wdata(fn_wdata), .fn_we(fn_we), .fn_re(fn_re),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_rdata(ram_rdata)
  );

  // behavioural RAMs with injectable faults
  logic [DW-1:0] mem [N][DEPTH];
  logic [DW-1:0] rd_q [N];
  bit sa_en [N];
  int sa_addr [N], sa_bit [N];
  bit sa_val [N];
  bit cp_en [N];
  int cp_aggr [N], cp_vict [N], cp_bit [N];

  function automatic logic [DW-1:0] rd_fn(int a, int ad);
    logic [DW-1:0] v;
    v = mem[a][ad];
    if (sa_en[a] && ad == sa_addr[a]) v[sa_bit[a]] = sa_val[a];
    return v;
  endfunction

  for (genvar a = 0; a < N; a++) begin : g_rd
    assign ram_rdata[a*DW +: DW] = rd_q[a];
  end

  initial begin
    for (int a = 0; a < N; a++) begin
      rd_q[a] = '0;
      sa_en[a] = 0; cp_en[a] = 0;
      for (int d = 0; d < DEPTH; d++) mem[a][d] = '0;
    end
  end

  always @(posedge clk) begin
    for (int a = 0; a < N; a++) begin
      int ad;
      ad = int'(ram_addr[a*AW +: AW]);
      if (ram_we[a]) begin
        mem[a][ad] <= ram_wdata[a*DW +: DW];
        if (cp_en[a] && ad == cp_aggr[a])
          mem[a][cp_vict[a]][cp_bit[a]] <= ram_wdata[a*DW + cp_bit[a]];
      end
      if (ram_re[a]) rd_q[a] <= rd_fn(a, ad);
    end
  end

  // reference march model
  int            q_addr[$];
  bit            q_wr[$];
  logic [DW-1:0] q_dat[$];
  int e_len [6] = '{1, 2, 2, 2, 3, 1};
  bit e_dn  [6] = '{0, 0, 0, 1, 1, 0};
  // 0 = read bg, 1 = read ~bg, 2 = write bg, 3 = write ~bg
  int e_op [6][3] = '{'{2,0,0}, '{0,3,0}, '{1,2,0}, '{0,3,0}, '{1,2,0}, '{0,0,0}};

  function automatic logic [DW-1:0] bg_pat(int k);
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++) p[i] = (k == 0) ? 1'b0 : (((i >> (k-1)) & 1) == 1);
    return p;
  endfunction

  task automatic build_ref();
    q_addr.delete(); q_wr.delete(); q_dat.delete();
    for (int k = 0; k < NBG; k++)
      for (int e = 0; e < 6; e++)
        for (int s = 0; s < DEPTH; s++)
          for (int i = 0; i < e_len[e]; i++) begin
            int op;
            op = e_op[e][i];
            q_addr.push_back(e_dn[e] ? DEPTH-1-s : s);
            q_wr.push_back(op >= 2);
            q_dat.push_back((op % 2 == 1) ? ~bg_pat(k) : bg_pat(k));
          end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run_bist(bit disturb, output logic [N-1:0] exp_fail);
    exp_fail = '0;
    build_ref();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(fail == '0 && done == 1'b0 && busy == 1'b1, "R7", "state after start",
          {fail, done, busy}, 6'b000001);
    for (int k = 0; k < q_addr.size(); k++) begin
      bit ok;
      if (k > 0) @(negedge clk);
      ok = busy;
      for (int a = 0; a < N; a++) begin
        if (int'(ram_addr[a*AW +: AW]) != q_addr[k]) ok = 0;
        if (ram_we[a] != q_wr[k] || ram_re[a] != !q_wr[k]) ok = 0;
        if (q_wr[k] && ram_wdata[a*DW +: DW] != q_dat[k]) ok = 0;
        if (!q_wr[k] && rd_fn(a, q_addr[k]) != q_dat[k]) exp_fail[a] = 1'b1;
      end
      check(ok, "R2/R3/R4/R5/R9", $sformatf("op %0d addr/we/re/data", k),
            {ram_addr[AW-1:0], ram_we[0], ram_re[0], ram_wdata[DW-1:0]},
            {q_addr[k][AW-1:0], q_wr[k], !q_wr[k], q_dat[k]});
      if (disturb) begin
        start    = (k == 100);
        fn_addr  = FAW'($urandom);
        fn_wdata = FDW'($urandom);
        fn_we    = N'($urandom);
        fn_re    = N'($urandom);
      end
    end
    @(negedge clk); start = 1'b0;
    check(busy && ram_we == '0 && ram_re == '0, "R8", "flush cycle",
          {busy, ram_we, ram_re}, {1'b1, {2*N{1'b0}}});
    @(negedge clk);
    check(done && !busy, "R8", "done after flush", {done, busy}, 2'b10);
    check(fail == exp_fail, "R6", "fail flags", fail, exp_fail);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ef;
    repeat (3) @(negedge clk);
    fn_addr = 16'h9a3c; fn_wdata = 32'hdeadbeef; fn_we = 4'b0101; fn_re = 4'b1010;
    #1;
    check(!done && !busy && fail == '0, "R1", "reset outputs", {done, busy, fail}, 0);
    check(ram_addr == fn_addr && ram_wdata == fn_wdata && ram_we == fn_we && ram_re == fn_re,
          "R1", "ram pins follow functional in reset", ram_addr, fn_addr);
    @(negedge clk); rst_n = 1'b1;
    fn_we = '0; fn_re = '0;

    // fault-free run
    run_bist(0, ef);
    check(ef == '0, "R6", "no fault expected", ef, 0);

    // R9: functional path restored after done
    fn_addr = 16'h1234; fn_wdata = 32'h0badf00d; fn_we = 4'b0011; fn_re = 4'b1100;
    #1;
    check(ram_addr == fn_addr && ram_wdata == fn_wdata && ram_we == fn_we && ram_re == fn_re,
          "R9", "functional after done", {ram_we, ram_re}, {fn_we, fn_re});
    fn_we = '0; fn_re = '0;

    // faulty arrays: stuck-at-1, stuck-at-0, coupling; array 0 clean
    sa_en[1] = 1; sa_addr[1] = 5;  sa_bit[1] = 3; sa_val[1] = 1;
    sa_en[2] = 1; sa_addr[2] = 12; sa_bit[2] = 7; sa_val[2] = 0;
    cp_en[3] = 1; cp_aggr[3] = 2;  cp_vict[3] = 9; cp_bit[3] = 0;
    run_bist(1, ef);
    check(ef == 4'b1110, "R6", "model flags faulty arrays", ef, 4'b1110);
    fn_we = '0; fn_re = '0;
    repeat (3) @(negedge clk);
    check(fail == 4'b1110 && done, "R6", "fail sticky after done", fail, 4'b1110);

    // restart from done clears flags
    sa_en[1] = 0; sa_en[2] = 0; cp_en[3] = 0;
    run_bist(0, ef);
    check(fail == '0, "R7", "flags cleared by new run", fail, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule